// File: doc/BRIEF.md
# Tag Response Frame Encoder

This block turns the bytes of a contactless tag's reply into the on/off signal that switches the antenna load. It runs on the carrier clock. A free-running carrier-cycle counter splits time into slots of 256 cycles, and it also supplies the subcarrier at carrier/32. Each slot is either silent, or it carries eight full subcarrier pulses. A frame is a fixed eight-slot start pattern, then two slots for every data bit, then a fixed eight-slot end pattern.

Bytes arrive over a valid/ready handshake, and a flag marks the last byte. A frame opens on a start pulse, or when a valid byte is seen while the block is idle. After the marked last byte has been sent, the end pattern follows. If no byte is available when one is needed, the block reports an underrun and sends the end pattern straight away. No slot is ever left half-coded.

Top module: `tag_resp_enc`

## Requirements
- R1: A pulsed slot lasts 256 clock cycles. It holds exactly 8 subcarrier periods, each 16 cycles low followed by 16 cycles high, and its first cycle is low.
- R2: A silent slot holds `mod_o` low for all 256 of its cycles.
- R3: Every frame opens with the slots 0,0,0,1,1,1,0,1 in time order (1 = pulsed).
- R4: Every frame closes with the slots 1,0,1,1,1,0,0,0 in time order.
- R5: Data bits go out least significant bit first. A 1 is sent as slots (0,1) and a 0 as slots (1,0). Bits 3:0 of a byte are sent before bits 7:4.
- R6: A frame opens on `start_i` or on `in_valid` while idle. Its first slot begins at a slot boundary, which falls a multiple of 256 cycles after reset is released.
- R7: `in_ready` is high for one cycle at most for each byte consumed, and only inside a frame. A byte is taken only when `in_valid` and `in_ready` are both high. The end pattern follows the upper half of the byte marked `in_last`.
- R8: If `in_valid` is low when a byte is needed, `underrun_o` pulses for exactly one cycle and the end pattern starts at once. A frame with no underrun never pulses `underrun_o`.
- R9: `busy_o` is high from the first cycle of the start pattern to the last cycle of the end pattern. `mod_o` is low whenever `busy_o` is low.
- R10: Synchronous reset, active high, forces idle: `busy_o`, `mod_o`, `in_ready` and `underrun_o` are all low, and this holds even if reset arrives in mid-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Requests a frame |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_ready | output | 1 | Byte is taken this cycle |
| in_data | input | 8 | Reply byte |
| in_last | input | 1 | Marks the final byte of the frame |
| mod_o | output | 1 | Load modulation gate |
| busy_o | output | 1 | Frame in progress |
| underrun_o | output | 1 | One-cycle pulse on an input underrun |

## Verification
Changes to slots and to `busy_o` take effect one cycle after the counter reaches 255. That is the first cycle of a slot, when the counter reads 0. The bench keeps its own cycle count from reset and checks that `busy_o` first reads high on a multiple of 256. It then integrates `mod_o` over each 256-cycle window to decide whether the slot was silent or pulsed. `in_ready` is combinational and is high during the last cycle of the slot before a code is loaded. The feeder samples it at the falling edge and moves to the next byte only after the following rising edge. `underrun_o` is registered, so it appears in the first cycle of the end pattern, and the bench counts its pulses over the whole frame.

// File: rtl/tre_pkg.sv
`timescale 1ns/1ps
package tre_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int CODE_W = 2 * NIB_W;

    // Slot patterns, MSB goes out first
    localparam logic [CODE_W-1:0] SOF_CODE = 8'b0001_1101;
    localparam logic [CODE_W-1:0] EOF_CODE = 8'b1011_1000;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SOF,
        PH_LO,
        PH_HI,
        PH_EOF
    } phase_e;

    typedef struct packed {
        logic              load;
        logic              clear;
        logic [CODE_W-1:0] code;
    } slot_cmd_t;

    // Expand a nibble, LSB first in time, into half-bit slot pairs
    function automatic logic [CODE_W-1:0] nib_code(input logic [NIB_W-1:0] nib);
        logic [CODE_W-1:0] c;
        c = '0;
        for (int i = 0; i < NIB_W; i++) begin
            c[CODE_W-1-2*i] = ~nib[i];
            c[CODE_W-2-2*i] =  nib[i];
        end
        return c;
    endfunction

endpackage

// File: rtl/tre_carrier_div.sv
`timescale 1ns/1ps
module tre_carrier_div #(
    parameter int SLOT_LOG2 = 8,
    parameter int SUB_BIT   = 4
) (
    input  logic clk,
    input  logic rst,
    output logic slot_end,
    output logic sub_o
);
    logic [SLOT_LOG2-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign slot_end = &cnt_q;
    assign sub_o    = cnt_q[SUB_BIT];
endmodule

// File: rtl/tre_slot_shift.sv
`timescale 1ns/1ps
module tre_slot_shift
    import tre_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  slot_cmd_t cmd,
    output logic      slot_on,
    output logic      last_slot
);
    localparam int LEFT_W = $clog2(CODE_W);

    logic [CODE_W-1:0] sh_q;
    logic [LEFT_W-1:0] left_q;
    logic              on_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            left_q <= '0;
            on_q   <= 1'b0;
        end else if (tick) begin
            if (cmd.load) begin
                on_q   <= cmd.code[CODE_W-1];
                sh_q   <= {cmd.code[CODE_W-2:0], 1'b0};
                left_q <= LEFT_W'(CODE_W - 1);
            end else if (cmd.clear) begin
                on_q   <= 1'b0;
                sh_q   <= '0;
                left_q <= '0;
            end else begin
                on_q <= sh_q[CODE_W-1];
                sh_q <= {sh_q[CODE_W-2:0], 1'b0};
                if (left_q != '0) left_q <= left_q - 1'b1;
            end
        end
    end

    assign slot_on   = on_q;
    assign last_slot = (left_q == '0);
endmodule

// File: rtl/tre_frame_ctrl.sv
`timescale 1ns/1ps
module tre_frame_ctrl
    import tre_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              last_slot,
    input  logic              start_i,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output slot_cmd_t         cmd,
    output logic              in_ready,
    output logic              busy_o,
    output logic              underrun_o
);
    phase_e           ph_q, ph_d;
    logic             pend_q, pend_d;
    logic [NIB_W-1:0] hi_q, hi_d;
    logic             last_q, last_d;
    logic             busy_q, busy_d;
    logic             und_q, und_d;
    logic             need_byte;
    logic             go;

    always_comb begin
        ph_d      = ph_q;
        pend_d    = pend_q;
        hi_d      = hi_q;
        last_d    = last_q;
        busy_d    = busy_q;
        und_d     = 1'b0;
        cmd       = '0;
        need_byte = (ph_q == PH_SOF) || (ph_q == PH_HI && !last_q);
        in_ready  = tick && last_slot && need_byte;
        go        = pend_q || start_i || in_valid;

        if (ph_q == PH_IDLE) begin
            if (tick && go) begin
                cmd.load = 1'b1;
                cmd.code = SOF_CODE;
                ph_d     = PH_SOF;
                busy_d   = 1'b1;
                pend_d   = 1'b0;
            end else if (go) begin
                pend_d = 1'b1;
            end
        end else if (tick && last_slot) begin
            if (need_byte) begin
                cmd.load = 1'b1;
                if (in_valid) begin
                    cmd.code = nib_code(in_data[NIB_W-1:0]);
                    hi_d     = in_data[BYTE_W-1:NIB_W];
                    last_d   = in_last;
                    ph_d     = PH_LO;
                end else begin
                    cmd.code = EOF_CODE;
                    und_d    = 1'b1;
                    ph_d     = PH_EOF;
                end
            end else if (ph_q == PH_LO) begin
                cmd.load = 1'b1;
                cmd.code = nib_code(hi_q);
                ph_d     = PH_HI;
            end else if (ph_q == PH_HI) begin
                cmd.load = 1'b1;
                cmd.code = EOF_CODE;
                ph_d     = PH_EOF;
            end else begin
                cmd.clear = 1'b1;
                busy_d    = 1'b0;
                ph_d      = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            pend_q <= 1'b0;
            hi_q   <= '0;
            last_q <= 1'b0;
            busy_q <= 1'b0;
            und_q  <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            pend_q <= pend_d;
            hi_q   <= hi_d;
            last_q <= last_d;
            busy_q <= busy_d;
            und_q  <= und_d;
        end
    end

    assign busy_o     = busy_q;
    assign underrun_o = und_q;
endmodule

// File: rtl/tag_resp_enc.sv
`timescale 1ns/1ps
module tag_resp_enc
    import tre_pkg::*;
#(
    parameter int SLOT_LOG2 = 8,
    parameter int SUB_BIT   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              mod_o,
    output logic              busy_o,
    output logic              underrun_o
);
    logic      tick;
    logic      sub;
    logic      slot_on;
    logic      last_slot;
    slot_cmd_t cmd;

    tre_carrier_div #(.SLOT_LOG2(SLOT_LOG2), .SUB_BIT(SUB_BIT)) u_div (
        .clk      (clk),
        .rst      (rst),
        .slot_end (tick),
        .sub_o    (sub)
    );

    tre_frame_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .last_slot  (last_slot),
        .start_i    (start_i),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .cmd        (cmd),
        .in_ready   (in_ready),
        .busy_o     (busy_o),
        .underrun_o (underrun_o)
    );

    tre_slot_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cmd       (cmd),
        .slot_on   (slot_on),
        .last_slot (last_slot)
    );

    assign mod_o = slot_on & sub;
endmodule

// File: rtl/tre_checker.sv
`timescale 1ns/1ps
module tre_checker #(
    parameter int SUB_BIT = 4
) (
    input logic clk,
    input logic rst,
    input logic mod_o,
    input logic busy_o,
    input logic in_ready,
    input logic underrun_o
);
    localparam int HALF = 2 ** SUB_BIT;

    logic [SUB_BIT+1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)        run_q <= '0;
        else if (mod_o) run_q <= run_q + 1'b1;
        else            run_q <= '0;
    end

    // R1
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mod_o) |-> (run_q == (SUB_BIT+2)'(HALF)));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mod_o);

    // R7
    ready_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> busy_o);

    // R7
    ready_single_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> !in_ready);

    // R8
    underrun_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        underrun_o |=> !underrun_o);

    // R8
    underrun_busy_chk: assert property (@(posedge clk) disable iff (rst)
        underrun_o |-> busy_o);

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!busy_o && !underrun_o));
endmodule

bind tag_resp_enc tre_checker #(.SUB_BIT(SUB_BIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mod_o      (mod_o),
    .busy_o     (busy_o),
    .in_ready   (in_ready),
    .underrun_o (underrun_o)
);

// File: tb/sim_tag_resp_enc.sv
`timescale 1ns/1ps
module sim_tag_resp_enc;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       mod_o;
    logic       busy_o;
    logic       underrun_o;

    int checks = 0;
    int errors = 0;
    int bc = 0;          // cycles since reset release
    int accepted;
    bit exp_s [0:127];
    bit got_s [0:127];
    int exp_n;
    logic [7:0] tx [0:7];

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) bc <= 0;
        else     bc <= bc + 1;
    end

    tag_resp_enc u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .mod_o(mod_o), .busy_o(busy_o), .underrun_o(underrun_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_slots(input logic [7:0] pat);
        for (int i = 7; i >= 0; i--) begin
            exp_s[exp_n] = pat[i];
            exp_n++;
        end
    endtask

    // Expected slot list built from R3, R4, R5
    task automatic build_exp(input int n);
        exp_n = 0;
        push_slots(8'b0001_1101);
        for (int b = 0; b < n; b++) begin
            for (int k = 0; k < 8; k++) begin
                exp_s[exp_n]   = ~tx[b][k];
                exp_s[exp_n+1] =  tx[b][k];
                exp_n += 2;
            end
        end
        push_slots(8'b1011_1000);
    endtask

    task automatic feed(input int n, input bit mark_last, input bit use_start, input int gap);
        accepted = 0;
        if (use_start) begin
            @(negedge clk); start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
            repeat (gap) @(negedge clk);
        end
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = tx[i];
            in_last  = mark_last && (i == n - 1);
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
            accepted++;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic capture(output int nslots, output int npulse);
        int highs, rises;
        bit prev;
        nslots = 0;
        npulse = 0;
        do @(negedge clk); while (!busy_o);
        // R6: first slot on a boundary
        chk(bc % 256 == 0, "R6 frame start alignment", bc % 256, 0);
        while (busy_o) begin
            highs = 0; rises = 0; prev = 1'b0;
            for (int k = 0; k < 256; k++) begin
                if (k == 0) chk(!mod_o, "R1 slot starts low", int'(mod_o), 0);
                if (mod_o) highs++;
                if (mod_o && !prev) rises++;
                if (underrun_o) npulse++;
                prev = mod_o;
                @(negedge clk);
            end
            got_s[nslots] = (highs >= 64);
            if (highs >= 64) begin
                chk(highs == 128, "R1 pulsed slot high cycles", highs, 128);
                chk(rises == 8, "R1 pulses per slot", rises, 8);
            end else begin
                chk(highs == 0, "R2 silent slot", highs, 0);
            end
            if (nslots < 127) nslots++;
        end
        chk(!mod_o, "R9 output low after frame", int'(mod_o), 0);
    endtask

    task automatic run_frame(input int n, input bit mark_last, input bit use_start,
                             input int gap, input int exp_n_acc, input int exp_und);
        int ns, np;
        fork
            feed(n, mark_last, use_start, gap);
            capture(ns, np);
        join
        build_exp(exp_n_acc);
        chk(accepted == exp_n_acc, "R7 bytes consumed", accepted, exp_n_acc);
        chk(np == exp_und, "R8 underrun pulses", np, exp_und);
        chk(ns == exp_n, "R9 frame length in slots", ns, exp_n);
        for (int i = 0; i < exp_n && i < ns; i++) begin
            if (i < 8)
                chk(got_s[i] == exp_s[i], "R3 start slot", int'(got_s[i]), int'(exp_s[i]));
            else if (i >= exp_n - 8)
                chk(got_s[i] == exp_s[i], "R4 end slot", int'(got_s[i]), int'(exp_s[i]));
            else
                chk(got_s[i] == exp_s[i], "R5 data slot", int'(got_s[i]), int'(exp_s[i]));
        end
        repeat (300) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (i % 100 == 0) begin
                chk(!busy_o && !mod_o, "R10 idle after reset", int'(busy_o) + int'(mod_o), 0);
                chk(!in_ready && !underrun_o, "R10 handshake quiet", int'(in_ready), 0);
            end
        end
    endtask

    task automatic t_single_zero;      // valid while idle opens frame
        tx[0] = 8'h00;
        run_frame(1, 1'b1, 1'b0, 0, 1, 0);
    endtask

    task automatic t_multi_start;      // start pulse opens frame
        tx[0] = 8'h1F; tx[1] = 8'h8A; tx[2] = 8'hF0;
        run_frame(3, 1'b1, 1'b1, 300, 3, 0);
    endtask

    task automatic t_underrun;
        tx[0] = 8'h3C;
        run_frame(1, 1'b0, 1'b0, 0, 1, 1);
    endtask

    task automatic t_empty_start;
        run_frame(0, 1'b0, 1'b1, 0, 0, 1);
    endtask

    task automatic t_reset_mid;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        do @(negedge clk); while (!busy_o);
        repeat (700) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy_o && !mod_o, "R10 mid-frame reset", int'(busy_o) + int'(mod_o), 0);
        rst = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (busy_o || mod_o) begin
                chk(1'b0, "R10 stays idle after reset", int'(busy_o), 0);
                break;
            end
        end
        checks++;
    endtask

    initial begin
        t_reset();
        t_single_zero();
        t_multi_start();
        t_underrun();
        t_empty_start();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule